// File: doc/BRIEF.md
# Header/Payload Rejoin Unit

This block sits where an arriving packet has already been cut into a header part and a payload part. When a packet is taken in, both parts receive one tag that no other packet in flight holds. The payload is parked in an eight-entry store keyed by that tag. The header leaves on its own path, together with the tag, toward an external route-processing agent.

The agent sends processed headers back in whatever order it finishes them. Each returned header carries its tag and the egress port the agent chose. The block looks up the parked payload by tag, frees its entry and streams out the rejoined packet: header words first, then payload words. The chosen port is presented next to the stream for a downstream demultiplexer.

A side read port lets the agent copy a parked payload by tag, for example when the header says the payload holds routing options. This read does not remove the entry. A returned header whose tag matches nothing parked is dropped, and a sticky error flag is raised.

Top module: `hdr_pay_rejoin`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid`, `hx_valid`, `rd_done` and `err_miss` are 0.
- R2: A packet accepted on a rising edge (`in_valid` and `in_ready` both high) produces `hx_valid`=1 in the next cycle, with `hx_hdr` equal to the accepted header and `hx_tag` equal to its tag.
- R3: `in_ready` is 0 while all eight store entries are occupied, and no packet is accepted then.
- R4: A returned header accepted on an edge (`rt_valid` and `rt_ready` high) whose tag is parked makes `out_valid` high from the next cycle. The output then carries 2 header beats followed by 4 payload beats. Beat i takes bits [16*i +: 16] of the returned header, or of the parked payload for the payload beats. `out_last` is 1 only on the sixth beat, `out_port` equals `rt_port` on every beat, and `out_valid` falls after the last beat is accepted.
- R5: Headers returned in an order different from ingress order are each joined with the payload of their own tag.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_last` and `out_port` stay unchanged.
- R7: `rt_ready` is 0 whenever `out_valid` is 1.
- R8: A rejoin frees the entry: a later header returned with the same tag is treated as a miss.
- R9: An accepted returned header whose tag is not parked produces no output beat and sets `err_miss`, which then stays 1 until reset.
- R10: A side read request (`rd_valid`) gives `rd_done`=1 in the next cycle. `rd_hit` tells whether the tag was parked, and `rd_pay` is the parked payload on a hit. The entry stays parked after the read.
- R11: When `rd_valid` and `rt_valid` are high in the same cycle with equal tags, `rt_ready` is 0 in that cycle, so the read is served first. With different tags, the returned header is not held back.
- R12: A newly issued `hx_tag` never equals the tag of a packet that is still parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Ingress packet offered |
| in_ready | output | 1 | Ingress can accept (free entry and free tag) |
| in_hdr | input | 32 | Ingress header, word 0 in low bits |
| in_pay | input | 64 | Ingress payload, word 0 in low bits |
| hx_valid | output | 1 | Header issued toward the route agent |
| hx_tag | output | 4 | Tag of the issued header |
| hx_hdr | output | 32 | Issued header |
| rt_valid | input | 1 | Processed header returned |
| rt_ready | output | 1 | Returned header can be taken |
| rt_tag | input | 4 | Tag of the returned header |
| rt_hdr | input | 32 | Processed header contents |
| rt_port | input | 3 | Egress port chosen by the agent |
| rd_valid | input | 1 | Side read request |
| rd_tag | input | 4 | Tag to read |
| rd_done | output | 1 | Side read answer valid |
| rd_hit | output | 1 | Tag was parked |
| rd_pay | output | 64 | Parked payload copy |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts beat |
| out_data | output | 16 | Output beat |
| out_last | output | 1 | Final beat of packet |
| out_port | output | 3 | Egress port for the packet |
| err_miss | output | 1 | Sticky flag: returned header matched nothing |

## Verification
A corrupted valid bit or tag in the lookup store shows up the first time that tag comes back. Either a stray miss raises `err_miss` and the stream stays silent, or a packet leaves with the payload of another tag, visible in the third beat after acceptance. A stale entry also shows as an extra side-read hit or a wrong `in_ready` when the store fills. Faults in the output stage show within one beat, as shifted words, a misplaced `out_last` or data that moves under backpressure. Returning headers in reverse and random order, with stalls, brings each of these out within a few packets.

// File: rtl/rj_pkg.sv
package rj_pkg;
  typedef enum logic {
    EM_IDLE = 1'b0,
    EM_SEND = 1'b1
  } em_state_t;
endpackage

// File: rtl/rj_tag_cam.sv
module rj_tag_cam #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     set_en,
  input  logic [$clog2(DEPTH)-1:0] set_idx,
  input  logic [TAG_W-1:0]         set_tag,
  input  logic                     clr_en,
  input  logic [$clog2(DEPTH)-1:0] clr_idx,
  input  logic [TAG_W-1:0]         q_tag_a,
  input  logic [TAG_W-1:0]         q_tag_b,
  input  logic [TAG_W-1:0]         q_tag_c,
  output logic                     hit_a,
  output logic [$clog2(DEPTH)-1:0] idx_a,
  output logic                     hit_b,
  output logic [$clog2(DEPTH)-1:0] idx_b,
  output logic                     hit_c,
  output logic                     free_any,
  output logic [$clog2(DEPTH)-1:0] free_idx,
  output logic [DEPTH-1:0]         ent_valid
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [TAG_W-1:0] ent_tag [DEPTH];
  logic [DEPTH-1:0] m_a, m_b, m_c;

  // one comparator per entry and per lookup
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign m_a[g] = ent_valid[g] && (ent_tag[g] == q_tag_a);
    assign m_b[g] = ent_valid[g] && (ent_tag[g] == q_tag_b);
    assign m_c[g] = ent_valid[g] && (ent_tag[g] == q_tag_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= '0;
    end else begin
      if (clr_en) ent_valid[clr_idx] <= 1'b0;
      if (set_en) ent_valid[set_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) ent_tag[set_idx] <= set_tag;
  end

  // tags are unique among valid entries, so at most one match bit is set
  always_comb begin
    idx_a    = '0;
    idx_b    = '0;
    free_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_a[i]) idx_a = IDX_W'(i);
      if (m_b[i]) idx_b = IDX_W'(i);
    end
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign hit_a    = |m_a;
  assign hit_b    = |m_b;
  assign hit_c    = |m_c;
  assign free_any = ~&ent_valid;
endmodule

// File: rtl/rj_pay_store.sv
module rj_pay_store #(
  parameter int DEPTH = 8,
  parameter int PW    = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] widx,
  input  logic [PW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] ridx_a,
  output logic [PW-1:0]            rdata_a,
  input  logic [$clog2(DEPTH)-1:0] ridx_b,
  output logic [PW-1:0]            rdata_b
);
  logic [PW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata_a = mem[ridx_a];
  assign rdata_b = mem[ridx_b];
endmodule

// File: rtl/rj_emit.sv
module rj_emit #(
  parameter int DW        = 16,
  parameter int HDR_WORDS = 2,
  parameter int PAY_WORDS = 4,
  parameter int PORT_W    = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [HDR_WORDS*DW-1:0] load_hdr,
  input  logic [PAY_WORDS*DW-1:0] load_pay,
  input  logic [PORT_W-1:0]       load_port,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DW-1:0]           out_data,
  output logic                    out_last,
  output logic [PORT_W-1:0]       out_port
);
  import rj_pkg::*;

  localparam int TOT    = HDR_WORDS + PAY_WORDS;
  localparam int BEAT_W = $clog2(TOT);

  em_state_t         st;
  logic [TOT*DW-1:0] pkt_q;
  logic [BEAT_W-1:0] beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= EM_IDLE;
      beat <= '0;
    end else if (load) begin
      st   <= EM_SEND;
      beat <= '0;
    end else if (st == EM_SEND && out_ready) begin
      if (beat == BEAT_W'(TOT - 1)) st <= EM_IDLE;
      else                          beat <= beat + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      pkt_q    <= {load_pay, load_hdr};
      out_port <= load_port;
    end else if (st == EM_SEND && out_ready) begin
      pkt_q <= pkt_q >> DW;
    end
  end

  assign out_valid = (st == EM_SEND);
  assign out_data  = pkt_q[DW-1:0];
  assign out_last  = (beat == BEAT_W'(TOT - 1));
endmodule

// File: rtl/hdr_pay_rejoin.sv
module hdr_pay_rejoin #(
  parameter int DEPTH     = 8,
  parameter int TAG_W     = 4,
  parameter int DW        = 16,
  parameter int HDR_WORDS = 2,
  parameter int PAY_WORDS = 4,
  parameter int PORT_W    = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [HDR_WORDS*DW-1:0] in_hdr,
  input  logic [PAY_WORDS*DW-1:0] in_pay,
  output logic                    hx_valid,
  output logic [TAG_W-1:0]        hx_tag,
  output logic [HDR_WORDS*DW-1:0] hx_hdr,
  input  logic                    rt_valid,
  output logic                    rt_ready,
  input  logic [TAG_W-1:0]        rt_tag,
  input  logic [HDR_WORDS*DW-1:0] rt_hdr,
  input  logic [PORT_W-1:0]       rt_port,
  input  logic                    rd_valid,
  input  logic [TAG_W-1:0]        rd_tag,
  output logic                    rd_done,
  output logic                    rd_hit,
  output logic [PAY_WORDS*DW-1:0] rd_pay,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DW-1:0]           out_data,
  output logic                    out_last,
  output logic [PORT_W-1:0]       out_port,
  output logic                    err_miss
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PW    = PAY_WORDS * DW;

  logic [TAG_W-1:0] tag_cnt;
  logic [DEPTH-1:0] ent_valid;
  logic             hit_rt, hit_rd, tag_busy, free_any;
  logic [IDX_W-1:0] idx_rt, idx_rd, free_idx;
  logic [PW-1:0]    pay_rt, pay_rd;
  logic             in_fire, rt_fire, rejoin, collide;

  assign in_ready = free_any && !tag_busy;
  assign in_fire  = in_valid && in_ready;
  assign collide  = rt_valid && rd_valid && (rt_tag == rd_tag);
  assign rt_ready = !out_valid && !collide;
  assign rt_fire  = rt_valid && rt_ready;
  assign rejoin   = rt_fire && hit_rt;

  rj_tag_cam #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_cam (
    .clk      (clk),
    .rst      (rst),
    .set_en   (in_fire),
    .set_idx  (free_idx),
    .set_tag  (tag_cnt),
    .clr_en   (rejoin),
    .clr_idx  (idx_rt),
    .q_tag_a  (rt_tag),
    .q_tag_b  (rd_tag),
    .q_tag_c  (tag_cnt),
    .hit_a    (hit_rt),
    .idx_a    (idx_rt),
    .hit_b    (hit_rd),
    .idx_b    (idx_rd),
    .hit_c    (tag_busy),
    .free_any (free_any),
    .free_idx (free_idx),
    .ent_valid(ent_valid)
  );

  rj_pay_store #(.DEPTH(DEPTH), .PW(PW)) u_store (
    .clk    (clk),
    .we     (in_fire),
    .widx   (free_idx),
    .wdata  (in_pay),
    .ridx_a (idx_rt),
    .rdata_a(pay_rt),
    .ridx_b (idx_rd),
    .rdata_b(pay_rd)
  );

  rj_emit #(.DW(DW), .HDR_WORDS(HDR_WORDS), .PAY_WORDS(PAY_WORDS), .PORT_W(PORT_W)) u_emit (
    .clk      (clk),
    .rst      (rst),
    .load     (rejoin),
    .load_hdr (rt_hdr),
    .load_pay (pay_rt),
    .load_port(rt_port),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_last (out_last),
    .out_port (out_port)
  );

  // tag counter skips a value that is still parked
  always_ff @(posedge clk) begin
    if (rst) tag_cnt <= '0;
    else if (in_fire || tag_busy) tag_cnt <= tag_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hx_valid <= 1'b0;
      rd_done  <= 1'b0;
      rd_hit   <= 1'b0;
      err_miss <= 1'b0;
    end else begin
      hx_valid <= in_fire;
      rd_done  <= rd_valid;
      rd_hit   <= rd_valid && hit_rd;
      if (rt_fire && !hit_rt) err_miss <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire) begin
      hx_tag <= tag_cnt;
      hx_hdr <= in_hdr;
    end
    if (rd_valid) rd_pay <= pay_rd;
  end
endmodule

// File: rtl/rj_chk.sv
module rj_chk #(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 4,
  parameter int DW     = 16,
  parameter int PORT_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              hx_valid,
  input logic              rt_valid,
  input logic              rt_ready,
  input logic [TAG_W-1:0]  rt_tag,
  input logic              rd_valid,
  input logic [TAG_W-1:0]  rd_tag,
  input logic              rd_done,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_last,
  input logic [DW-1:0]     out_data,
  input logic [PORT_W-1:0] out_port,
  input logic              err_miss,
  input logic [DEPTH-1:0]  ent_valid
);
  // R2
  ingress_issue_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> hx_valid);
  // R3
  full_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (&ent_valid) |-> !in_ready);
  // R4
  last_beat_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !out_valid);
  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last) && $stable(out_port));
  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !rt_ready);
  // R9
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    err_miss |=> err_miss);
  // R10
  read_answer_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> rd_done);
  // R11
  read_first_chk: assert property (@(posedge clk) disable iff (rst)
    rt_valid && rd_valid && (rt_tag == rd_tag) |-> !rt_ready);
endmodule

bind hdr_pay_rejoin rj_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DW(DW), .PORT_W(PORT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .hx_valid (hx_valid),
  .rt_valid (rt_valid),
  .rt_ready (rt_ready),
  .rt_tag   (rt_tag),
  .rd_valid (rd_valid),
  .rd_tag   (rd_tag),
  .rd_done  (rd_done),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_last (out_last),
  .out_data (out_data),
  .out_port (out_port),
  .err_miss (err_miss),
  .ent_valid(ent_valid)
);

// File: tb/hdr_pay_rejoin_tb.sv
`timescale 1ns/1ps
module hdr_pay_rejoin_tb;
  localparam int NTAG = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, rt_valid = 1'b0, rd_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] in_hdr = '0, rt_hdr = '0, hx_hdr;
  logic [63:0] in_pay = '0, rd_pay;
  logic [3:0]  rt_tag = '0, rd_tag = '0, hx_tag;
  logic [2:0]  rt_port = '0, out_port;
  logic        in_ready, hx_valid, rt_ready, rd_done, rd_hit, out_valid, out_last, err_miss;
  logic [15:0] out_data;

  int          nchk = 0, nfail = 0, cyc = 0, ninfl = 0;
  bit          done = 1'b0;
  bit          infl [NTAG];
  logic [63:0] mpay [NTAG];
  int          order [8];

  always #4 clk = ~clk;

  hdr_pay_rejoin u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_hdr(in_hdr),
    .in_pay(in_pay), .hx_valid(hx_valid), .hx_tag(hx_tag), .hx_hdr(hx_hdr),
    .rt_valid(rt_valid), .rt_ready(rt_ready), .rt_tag(rt_tag), .rt_hdr(rt_hdr),
    .rt_port(rt_port), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_done(rd_done),
    .rd_hit(rd_hit), .rd_pay(rd_pay), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .out_port(out_port), .err_miss(err_miss)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_beat(input int b, input logic [31:0] h, input logic [63:0] p);
    if (b < 2) return h[b*16 +: 16];
    return p[(b-2)*16 +: 16];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic do_in(input logic [31:0] h, input logic [63:0] p, output int t);
    @(negedge clk);
    in_hdr = h; in_pay = p; in_valid = 1'b1; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk(hx_valid == 1'b1, "R2 hx_valid", 64'(hx_valid), 64'd1);
    chk(hx_hdr == h, "R2 hx_hdr", 64'(hx_hdr), 64'(h));
    t = int'(hx_tag);
    chk(!infl[t], "R12 tag reuse", 64'(t), 64'hffff);
    infl[t] = 1'b1; mpay[t] = p; ninfl++;
  endtask

  task automatic collect(input logic [31:0] h, input logic [63:0] p, input logic [2:0] pt, input bit stall);
    for (int b = 0; b < 6; b++) begin
      chk(out_valid == 1'b1, "R4 valid", 64'(out_valid), 64'd1);
      chk(out_data == exp_beat(b, h, p), "R4 R5 data", 64'(out_data), 64'(exp_beat(b, h, p)));
      chk(out_last == (b == 5), "R4 last", 64'(out_last), 64'(b == 5));
      chk(out_port == pt, "R4 port", 64'(out_port), 64'(pt));
      chk(rt_ready == 1'b0, "R7 rt_ready", 64'(rt_ready), 64'd0);
      if (stall && $urandom_range(0, 1) == 1) begin
        out_ready = 1'b0;
        @(negedge clk);
        chk(out_valid && out_data == exp_beat(b, h, p) && out_port == pt && out_last == (b == 5),
            "R6 hold", 64'(out_data), 64'(exp_beat(b, h, p)));
      end
      out_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      out_ready = 1'b0;
    end
    chk(out_valid == 1'b0, "R4 end", 64'(out_valid), 64'd0);
  endtask

  task automatic do_ret(input int t, input logic [31:0] h, input logic [2:0] pt, input bit stall);
    bit hit = infl[t];
    @(negedge clk);
    rt_valid = 1'b1; rt_tag = 4'(t); rt_hdr = h; rt_port = pt; #1;
    while (!rt_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    rt_valid = 1'b0;
    if (!hit) begin
      chk(out_valid == 1'b0, "R9 R8 no output", 64'(out_valid), 64'd0);
      chk(err_miss == 1'b1, "R9 err", 64'(err_miss), 64'd1);
    end else begin
      infl[t] = 1'b0; ninfl--;
      collect(h, mpay[t], pt, stall);
    end
  endtask

  task automatic do_rd(input int t);
    @(negedge clk);
    rd_valid = 1'b1; rd_tag = 4'(t);
    @(posedge clk); @(negedge clk);
    rd_valid = 1'b0;
    chk(rd_done == 1'b1, "R10 done", 64'(rd_done), 64'd1);
    chk(rd_hit == infl[t], "R10 hit", 64'(rd_hit), 64'(infl[t]));
    if (infl[t]) chk(rd_pay == mpay[t], "R10 pay", rd_pay, mpay[t]);
  endtask

  function automatic int pick();
    int s = $urandom_range(0, NTAG - 1);
    for (int k = 0; k < NTAG; k++)
      if (infl[(s + k) % NTAG]) return (s + k) % NTAG;
    return s;
  endfunction

  initial begin
    int t, t2;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NTAG; i++) begin infl[i] = 1'b0; mpay[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1
    chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    chk(hx_valid == 1'b0, "R1 hx_valid", 64'(hx_valid), 64'd0);
    chk(rd_done == 1'b0, "R1 rd_done", 64'(rd_done), 64'd0);
    chk(err_miss == 1'b0, "R1 err_miss", 64'(err_miss), 64'd0);

    // R9: miss on empty store
    do_ret(5, 32'hdead_beef, 3'd2, 1'b0);

    // R3: fill all entries
    for (int i = 0; i < 8; i++) begin
      do_in($urandom, {$urandom, $urandom}, t);
      order[i] = t;
    end
    @(negedge clk);
    in_valid = 1'b1; #1;
    chk(in_ready == 1'b0, "R3 full", 64'(in_ready), 64'd0);
    @(posedge clk); @(negedge clk);
    chk(hx_valid == 1'b0, "R3 no accept", 64'(hx_valid), 64'd0);
    in_valid = 1'b0;

    // R10: side reads keep entries
    for (int i = 0; i < 8; i++) do_rd(order[i]);
    do_rd(order[0]);

    // R5: return in reverse order with stalls
    for (int i = 7; i >= 0; i--) do_ret(order[i], $urandom, 3'($urandom_range(0, 7)), 1'b1);

    // R8: freed entry misses, and a read misses too
    do_ret(order[3], 32'h1234_5678, 3'd1, 1'b0);
    do_rd(order[3]);

    // R11: same-tag collision
    do_in($urandom, {$urandom, $urandom}, t);
    @(negedge clk);
    rd_valid = 1'b1; rd_tag = 4'(t);
    rt_valid = 1'b1; rt_tag = 4'(t); rt_hdr = 32'hcafe_f00d; rt_port = 3'd6; #1;
    chk(rt_ready == 1'b0, "R11 held", 64'(rt_ready), 64'd0);
    @(posedge clk); @(negedge clk);
    rd_valid = 1'b0;
    chk(rd_done && rd_hit, "R11 read first", 64'(rd_hit), 64'd1);
    chk(rd_pay == mpay[t], "R10 R11 pay", rd_pay, mpay[t]);
    #1;
    chk(rt_ready == 1'b1, "R11 released", 64'(rt_ready), 64'd1);
    @(posedge clk); @(negedge clk);
    rt_valid = 1'b0;
    infl[t] = 1'b0; ninfl--;
    collect(32'hcafe_f00d, mpay[t], 3'd6, 1'b0);

    // R11: different tags proceed together
    do_in($urandom, {$urandom, $urandom}, t);
    do_in($urandom, {$urandom, $urandom}, t2);
    @(negedge clk);
    rd_valid = 1'b1; rd_tag = 4'(t);
    rt_valid = 1'b1; rt_tag = 4'(t2); rt_hdr = 32'h0bad_1dea; rt_port = 3'd5; #1;
    chk(rt_ready == 1'b1, "R11 no block", 64'(rt_ready), 64'd1);
    @(posedge clk); @(negedge clk);
    rd_valid = 1'b0; rt_valid = 1'b0;
    chk(rd_done && rd_hit && rd_pay == mpay[t], "R10 parallel read", rd_pay, mpay[t]);
    infl[t2] = 1'b0; ninfl--;
    collect(32'h0bad_1dea, mpay[t2], 3'd5, 1'b0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int act = $urandom_range(0, 9);
      if (act < 4 && ninfl < 8) do_in($urandom, {$urandom, $urandom}, t);
      else if (act == 4) do_rd($urandom_range(0, NTAG - 1));
      else if (act == 9) do_ret($urandom_range(0, NTAG - 1), $urandom, 3'($urandom_range(0, 7)), 1'b1);
      else if (ninfl > 0) do_ret(pick(), $urandom, 3'($urandom_range(0, 7)), 1'b1);
    end

    // R9 sticky
    chk(err_miss == 1'b1, "R9 sticky", 64'(err_miss), 64'd1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule